// File: doc/BRIEF.md
# SIFS Response Trigger Evaluator

This block sits in a receive path after peer lookup and frame parsing. For every received frame that belongs to a known peer, it decides whether a short-interframe response data request interrupt should be raised. The frame side gives the frame class, the power-management bit, the 4-bit traffic identifier (TID) and a flag that marks an explicit throughput-boost trigger. The peer side gives five per-rule enable bits, a power-save TID trigger bitmap, a boost TID trigger bitmap and a 5-bit response table ID.

Each rule is gated by frame class and by the polarity of the power-management bit. Some rules also need the TID bit in one of the two bitmaps. The block registers a one-cycle interrupt pulse and a cause code. It also registers a response-table index, which is passed on only when a rule fired and the ID is not the null value.

Top module: `sifs_trig_eval`

## Requirements
- R1: With enable bit 0 set, a PS-Poll frame (class code 1) fires the interrupt with cause code 1, whatever the power-management bit, the TID and the boost flag are.
- R2: With enable bit 1 set, a QoS Data frame (class code 2) that has its power-management bit at 1 and bit TID set in the power-save bitmap fires with cause code 2.
- R3: With enable bit 3 set, a QoS Data frame that has its power-management bit at 0 and bit TID set in the boost bitmap fires with cause code 4.
- R4: With enable bit 4 set, a BAR frame (class code 3) that has its power-management bit at 0 and bit TID set in the boost bitmap fires with cause code 5.
- R5: With enable bit 2 set, a QoS Data or BAR frame that has its power-management bit at 0 and the explicit boost flag at 1 fires with cause code 3, for any TID.
- R6: In both bitmaps bit n stands for TID n, with 16 bits per bitmap. A frame for which no rule matches produces no pulse and cause code 0.
- R7: The response-table valid output rises only for a nonzero table ID. A table ID of 0 gives valid 0 and index 0, even when the interrupt fires.
- R8: When no pulse is raised, the table index, the table valid output and the cause code are all 0. A nonzero ID is passed on only together with a pulse.
- R9: The inputs are sampled on an edge where frame_valid is 1. The pulse appears for exactly the cycle after that edge. A cycle without the strobe produces no pulse.
- R10: When several rules match, the cause code names the first match in the order PS-Poll (1), power-save trigger (2), explicit boost (3), boost QoS data (4), boost BAR (5). A single pulse is still raised.
- R11: A frame of class code 0 (any other frame) never fires, whatever the enable bits and bitmaps hold.
- R12: Reset is synchronous and active-low. An edge with rst_n at 0 clears the pulse, the cause code, the table valid output and the table index, even when a strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: the frame and peer inputs are valid |
| frame_class | input | 2 | 0 other, 1 PS-Poll, 2 QoS Data, 3 BAR |
| frame_pm | input | 1 | Power-management bit of the received frame |
| frame_tid | input | TID_W | Traffic identifier of the frame |
| frame_boost_flag | input | 1 | Explicit boost trigger flag of the frame |
| peer_en | input | 5 | Rule enables: bit0 PS-Poll, bit1 power-save trigger, bit2 explicit boost, bit3 boost QoS data, bit4 boost BAR |
| peer_ps_map | input | 2**TID_W | Power-save trigger bitmap, indexed by TID |
| peer_boost_map | input | 2**TID_W | Boost trigger bitmap, indexed by TID |
| peer_tbl_id | input | TBL_W | Response table ID; 0 is the null value |
| irq_pulse | output | 1 | Registered one-cycle interrupt request |
| irq_cause | output | 3 | Cause code of the winning rule, 0 when idle |
| resp_tbl_vld | output | 1 | Table index is valid for this pulse |
| resp_tbl_idx | output | TBL_W | Qualified response table index, 0 when not valid |

## Verification
The assertions take for granted that frame_class, the TID and the peer fields are stable and meaningful in any cycle where frame_valid is 1. They do not care what these inputs hold in other cycles. The stimulus drives all inputs on the falling edge only. It raises the strobe on every other cycle, so each strobed frame is followed by an idle cycle in which the no-strobe behaviour shows up. The stimulus covers every class, power-management bit, TID, boost flag and enable combination. It does this under three bitmap pairs, which include empty, full and single-bit maps, and under table IDs that include 0.

// File: rtl/sifs_trig_pkg.sv
package sifs_trig_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER  = 2'd0,
      CLS_PSPOLL = 2'd1,
      CLS_QOS    = 2'd2,
      CLS_BAR    = 2'd3
   } frm_cls_e;

   // rule indices double as priority rank (0 = highest)
   localparam int N_RULES     = 5;
   localparam int RULE_PSPOLL = 0;
   localparam int RULE_PSTRIG = 1;
   localparam int RULE_EXPL   = 2;
   localparam int RULE_BQOS   = 3;
   localparam int RULE_BBAR   = 4;
   localparam int CAUSE_W     = $clog2(N_RULES + 1);

endpackage

// File: rtl/sifs_tid_sel.sv
module sifs_tid_sel #(
   parameter int TID_W  = 4,
   parameter bit ONEHOT = 1'b0
) (
   input  logic [(1<<TID_W)-1:0] map,
   input  logic [TID_W-1:0]      tid,
   output logic                  hit
);
   localparam int MAP_W = 1 << TID_W;

   generate
      if (ONEHOT) begin : g_onehot
         logic [MAP_W-1:0] dec;
         always_comb begin
            dec      = '0;
            dec[tid] = 1'b1;
         end
         assign hit = |(dec & map);
      end else begin : g_mux
         assign hit = map[tid];
      end
   endgenerate

endmodule

// File: rtl/sifs_rule_match.sv
module sifs_rule_match
   import sifs_trig_pkg::*;
#(
   parameter int TID_W         = 4,
   parameter bit ONEHOT_LOOKUP = 1'b0
) (
   input  frm_cls_e              cls,
   input  logic                  pm,
   input  logic [TID_W-1:0]      tid,
   input  logic                  boost_flag,
   input  logic [N_RULES-1:0]    en,
   input  logic [(1<<TID_W)-1:0] ps_map,
   input  logic [(1<<TID_W)-1:0] boost_map,
   output logic [N_RULES-1:0]    hits
);
   logic ps_bit;
   logic bst_bit;
   logic is_qos;
   logic is_bar;

   sifs_tid_sel #(.TID_W(TID_W), .ONEHOT(ONEHOT_LOOKUP)) u_ps_sel (
      .map (ps_map),
      .tid (tid),
      .hit (ps_bit)
   );

   sifs_tid_sel #(.TID_W(TID_W), .ONEHOT(ONEHOT_LOOKUP)) u_bst_sel (
      .map (boost_map),
      .tid (tid),
      .hit (bst_bit)
   );

   assign is_qos = (cls == CLS_QOS);
   assign is_bar = (cls == CLS_BAR);

   always_comb begin
      hits              = '0;
      hits[RULE_PSPOLL] = en[RULE_PSPOLL] & (cls == CLS_PSPOLL);
      hits[RULE_PSTRIG] = en[RULE_PSTRIG] & is_qos & pm & ps_bit;
      hits[RULE_EXPL]   = en[RULE_EXPL] & (is_qos | is_bar) & ~pm & boost_flag;
      hits[RULE_BQOS]   = en[RULE_BQOS] & is_qos & ~pm & bst_bit;
      hits[RULE_BBAR]   = en[RULE_BBAR] & is_bar & ~pm & bst_bit;
   end

endmodule

// File: rtl/sifs_prio_pick.sv
module sifs_prio_pick
   import sifs_trig_pkg::*;
(
   input  logic [N_RULES-1:0] hits,
   output logic [CAUSE_W-1:0] code
);
   // walk from lowest to highest rank so the highest rank wins
   always_comb begin
      code = '0;
      for (int i = N_RULES - 1; i >= 0; i--) begin
         if (hits[i]) code = CAUSE_W'(i + 1);
      end
   end

endmodule

// File: rtl/sifs_trig_eval.sv
module sifs_trig_eval
   import sifs_trig_pkg::*;
#(
   parameter int TID_W         = 4,
   parameter int TBL_W         = 5,
   parameter bit ONEHOT_LOOKUP = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frame_valid,
   input  logic [1:0]                    frame_class,
   input  logic                          frame_pm,
   input  logic [TID_W-1:0]              frame_tid,
   input  logic                          frame_boost_flag,
   input  logic [sifs_trig_pkg::N_RULES-1:0] peer_en,
   input  logic [(1<<TID_W)-1:0]         peer_ps_map,
   input  logic [(1<<TID_W)-1:0]         peer_boost_map,
   input  logic [TBL_W-1:0]              peer_tbl_id,
   output logic                          irq_pulse,
   output logic [sifs_trig_pkg::CAUSE_W-1:0] irq_cause,
   output logic                          resp_tbl_vld,
   output logic [TBL_W-1:0]              resp_tbl_idx
);
   generate
      if (TID_W < 1 || TID_W > 6) begin : g_bad_tid
         $error("sifs_trig_eval: TID_W must lie in 1..6");
      end
      if (TBL_W < 1) begin : g_bad_tbl
         $error("sifs_trig_eval: TBL_W must be at least 1");
      end
   endgenerate

   logic [N_RULES-1:0] hits;
   logic [CAUSE_W-1:0] code;
   logic               fire;
   logic               tbl_ok;

   sifs_rule_match #(.TID_W(TID_W), .ONEHOT_LOOKUP(ONEHOT_LOOKUP)) u_match (
      .cls        (frm_cls_e'(frame_class)),
      .pm         (frame_pm),
      .tid        (frame_tid),
      .boost_flag (frame_boost_flag),
      .en         (peer_en),
      .ps_map     (peer_ps_map),
      .boost_map  (peer_boost_map),
      .hits       (hits)
   );

   sifs_prio_pick u_pick (
      .hits (hits),
      .code (code)
   );

   assign fire   = frame_valid & (|hits);
   assign tbl_ok = fire & (|peer_tbl_id);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pulse    <= 1'b0;
         irq_cause    <= '0;
         resp_tbl_vld <= 1'b0;
         resp_tbl_idx <= '0;
      end else begin
         irq_pulse    <= fire;
         irq_cause    <= fire ? code : '0;
         resp_tbl_vld <= tbl_ok;
         resp_tbl_idx <= tbl_ok ? peer_tbl_id : '0;
      end
   end

endmodule

// File: rtl/sifs_trig_eval_chk.sv
module sifs_trig_eval_chk #(
   parameter int TID_W = 4,
   parameter int TBL_W = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   frame_valid,
   input logic [1:0]             frame_class,
   input logic                   frame_pm,
   input logic [TID_W-1:0]       frame_tid,
   input logic                   frame_boost_flag,
   input logic [4:0]             peer_en,
   input logic [(1<<TID_W)-1:0]  peer_ps_map,
   input logic [(1<<TID_W)-1:0]  peer_boost_map,
   input logic                   irq_pulse,
   input logic [2:0]             irq_cause,
   input logic                   resp_tbl_vld,
   input logic [TBL_W-1:0]       resp_tbl_idx
);
   // R1
   pspoll_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_class == 2'd1 && peer_en[0]) |=> (irq_pulse && irq_cause == 3'd1));

   // R2
   ps_trig_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_class == 2'd2 && frame_pm && peer_en[1] && peer_ps_map[frame_tid])
      |=> (irq_pulse && irq_cause == 3'd2));

   // R4
   boost_bar_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_class == 2'd3 && frame_pm) |=> !irq_pulse);

   // R9
   no_strobe_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(frame_valid));

   // R11
   other_class_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ($past(frame_class) != 2'd0));

   // R8
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pulse |-> (irq_cause == 3'd0 && !resp_tbl_vld && resp_tbl_idx == '0));

   // R7
   tbl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_tbl_vld |-> (resp_tbl_idx != '0 && irq_pulse));

   // R12
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (!irq_pulse && irq_cause == 3'd0 && !resp_tbl_vld && resp_tbl_idx == '0));

endmodule

bind sifs_trig_eval sifs_trig_eval_chk #(.TID_W(TID_W), .TBL_W(TBL_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .frame_valid      (frame_valid),
   .frame_class      (frame_class),
   .frame_pm         (frame_pm),
   .frame_tid        (frame_tid),
   .frame_boost_flag (frame_boost_flag),
   .peer_en          (peer_en),
   .peer_ps_map      (peer_ps_map),
   .peer_boost_map   (peer_boost_map),
   .irq_pulse        (irq_pulse),
   .irq_cause        (irq_cause),
   .resp_tbl_vld     (resp_tbl_vld),
   .resp_tbl_idx     (resp_tbl_idx)
);

// File: tb/sim_sifs_trig_eval.sv
`timescale 1ns/1ps
module sim_sifs_trig_eval;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_valid;
   logic [1:0]  frame_class;
   logic        frame_pm;
   logic [3:0]  frame_tid;
   logic        frame_boost_flag;
   logic [4:0]  peer_en;
   logic [15:0] peer_ps_map;
   logic [15:0] peer_boost_map;
   logic [4:0]  peer_tbl_id;
   logic        irq_pulse;
   logic [2:0]  irq_cause;
   logic        resp_tbl_vld;
   logic [4:0]  resp_tbl_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sifs_trig_eval u0 (
      .clk              (clk),
      .rst_n            (rst_n),
      .frame_valid      (frame_valid),
      .frame_class      (frame_class),
      .frame_pm         (frame_pm),
      .frame_tid        (frame_tid),
      .frame_boost_flag (frame_boost_flag),
      .peer_en          (peer_en),
      .peer_ps_map      (peer_ps_map),
      .peer_boost_map   (peer_boost_map),
      .peer_tbl_id      (peer_tbl_id),
      .irq_pulse        (irq_pulse),
      .irq_cause        (irq_cause),
      .resp_tbl_vld     (resp_tbl_vld),
      .resp_tbl_idx     (resp_tbl_idx)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(tag, "pulse", int'(irq_pulse), 0);
      chk(tag, "cause", int'(irq_cause), 0);
      chk(tag, "tbl_vld", int'(resp_tbl_vld), 0);
      chk(tag, "tbl_idx", int'(resp_tbl_idx), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] ps_tab [3];
      logic [15:0] bs_tab [3];
      ps_tab[0] = 16'hA5C3; bs_tab[0] = 16'h5A3C;
      ps_tab[1] = 16'h0001; bs_tab[1] = 16'h8000;
      ps_tab[2] = 16'hFFFF; bs_tab[2] = 16'h0000;

      rst_n = 1'b0; frame_valid = 1'b0; frame_class = 2'd0; frame_pm = 1'b0;
      frame_tid = '0; frame_boost_flag = 1'b0; peer_en = '0;
      peer_ps_map = '0; peer_boost_map = '0; peer_tbl_id = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_idle("R12");
      rst_n = 1'b1;

      for (int p = 0; p < 3; p++) begin
         for (int c = 0; c < 4; c++) begin
            for (int pm = 0; pm < 2; pm++) begin
               for (int t = 0; t < 16; t++) begin
                  for (int f = 0; f < 2; f++) begin
                     for (int e = 0; e < 32; e++) begin
                        logic [4:0] h;
                        int         exp_cause;
                        int         n_hit;
                        logic [4:0] id;
                        string      tag;
                        // R6: bit t of each map stands for TID t
                        id = 5'((e * 7 + t + p) & 31);
                        h[0] = e[0] && c == 1;                                       // R1
                        h[1] = e[1] && c == 2 && pm == 1 && ps_tab[p][t];            // R2
                        h[2] = e[2] && (c == 2 || c == 3) && pm == 0 && f == 1;      // R5
                        h[3] = e[3] && c == 2 && pm == 0 && bs_tab[p][t];            // R3
                        h[4] = e[4] && c == 3 && pm == 0 && bs_tab[p][t];            // R4
                        exp_cause = 0;
                        n_hit = 0;
                        for (int k = 4; k >= 0; k--) if (h[k]) exp_cause = k + 1;
                        for (int k = 0; k < 5; k++) if (h[k]) n_hit++;
                        if (c == 0)          tag = "R11";
                        else if (n_hit > 1)  tag = "R10";
                        else if (h[0])       tag = "R1";
                        else if (h[1])       tag = "R2";
                        else if (h[2])       tag = "R5";
                        else if (h[3])       tag = "R3";
                        else if (h[4])       tag = "R4";
                        else                 tag = "R6";

                        frame_valid = 1'b1; frame_class = 2'(c); frame_pm = 1'(pm);
                        frame_tid = 4'(t); frame_boost_flag = 1'(f); peer_en = 5'(e);
                        peer_ps_map = ps_tab[p]; peer_boost_map = bs_tab[p];
                        peer_tbl_id = id;
                        @(negedge clk);
                        chk(tag, "pulse", int'(irq_pulse), int'(n_hit > 0));
                        chk(tag, "cause", int'(irq_cause), exp_cause);
                        chk((n_hit > 0) ? "R7" : "R8", "tbl_vld", int'(resp_tbl_vld),
                            int'(n_hit > 0 && id != 0));
                        chk((n_hit > 0) ? "R7" : "R8", "tbl_idx", int'(resp_tbl_idx),
                            (n_hit > 0) ? int'(id) : 0);
                        // R9: strobe low for one cycle, peer fields left live
                        frame_valid = 1'b0;
                        frame_class = 2'd1;
                        peer_en = 5'h1F;
                        @(negedge clk);
                        chk_idle("R9");
                     end
                  end
               end
            end
         end
      end

      // R12: a strobe that meets a reset edge is dropped
      frame_valid = 1'b1; frame_class = 2'd1; peer_en = 5'h1F; peer_tbl_id = 5'd9;
      rst_n = 1'b0;
      @(negedge clk);
      chk_idle("R12");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pulse", int'(irq_pulse), 1);
      chk("R7", "tbl_idx", int'(resp_tbl_idx), 9);
      frame_valid = 1'b0;
      @(negedge clk);
      chk_idle("R9");

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule